// File: doc/BRIEF.md
# Timer Event Pin Driver

This block turns the overflow and compare-match pulses of a counter timer into the level on a timer output pin. A two-bit trigger mode picks which events are allowed to act on the pin. A select bit then decides what a qualifying event does: it either inverts the pin or produces a pulse that lasts one clock. The pulse is driven at the level opposite to the programmed idle level.

When triggering is off, or the timer is not running, the pin is forced to a software-programmed idle level. When the shared pin is configured as an input, the driver stops updating and holds its last level. The counter and input capture sit outside this block.

All inputs are sampled on the rising clock edge. The pin level comes from a register, so it cannot glitch. It changes exactly one clock after the inputs that caused the change.

Top module: `tep_pin_drv`

## Requirements
- R1: While `rst_n` is low at a rising edge, `pin_out` becomes 0 (parameter `RST_LVL`, default 0).
- R2: `trig_mode` encoding: 0 = no trigger, 1 = overflow only, 2 = overflow and match, 3 = reserved and treated exactly like 0.
- R3: With the pin as output (`pin_is_in` = 0), if `run` is 0 or the trigger mode is 0 or 3, `pin_out` equals `idle_lvl` one cycle later.
- R4: In toggle mode (`toggle_sel` = 1), an enabled and running driver inverts `pin_out` one cycle after an `ovf_evt` pulse.
- R5: In overflow-only mode (1), `mat_evt` alone has no effect on `pin_out`.
- R6: In overflow-and-match mode (2), `mat_evt` acts on the pin exactly as `ovf_evt` does, both in toggle mode and in pulse mode.
- R7: In toggle mode, overflow and match in the same cycle invert `pin_out` only once.
- R8: In pulse mode (`toggle_sel` = 0), a qualifying event drives `pin_out` to the inverse of `idle_lvl` for exactly one cycle. In every other cycle of that mode the pin is at `idle_lvl`.
- R9: In toggle mode, a cycle with no qualifying event leaves `pin_out` unchanged.
- R10: While `pin_is_in` = 1, `pin_out` holds its value, whatever the events, mode, run and idle inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ovf_evt | input | 1 | One-cycle counter overflow pulse |
| mat_evt | input | 1 | One-cycle compare-match pulse |
| trig_mode | input | 2 | Trigger mode (0 none, 1 overflow, 2 overflow and match, 3 reserved) |
| toggle_sel | input | 1 | 1 = event toggles pin, 0 = event pulses pin |
| idle_lvl | input | 1 | Level forced while idle; pulse polarity is its inverse |
| pin_is_in | input | 1 | 1 = shared pin is an input; driver holds |
| run | input | 1 | Timer running |
| pin_out | output | 1 | Registered pin level |

## Verification
The bench drives overflow and match together in toggle mode. A design that applied each event separately would invert the pin twice and leave it where it was. It sends match pulses in overflow-only mode, where a design that did not qualify the events would toggle. It uses the reserved mode with events present, where a design that decoded only mode 0 as off would react. It runs pulse mode at both idle levels, which exposes a fixed pulse polarity or a pulse that is not released. It also drives events and a changed idle level while the pin is an input, which catches a driver that forces the idle level or toggles regardless of direction.

// File: rtl/tep_pkg.sv
// Package: shared encodings for the timer event pin driver.
package tep_pkg;
    typedef enum logic [1:0] {
        TRIG_NONE = 2'd0,
        TRIG_OVF  = 2'd1,
        TRIG_BOTH = 2'd2,
        TRIG_RSVD = 2'd3
    } trig_mode_e;
endpackage

// File: rtl/tep_evt_qual.sv
// Event qualifier: decides whether the driver is armed and whether this
// cycle carries an event that acts on the pin.
// Assumes event inputs are single-cycle pulses synchronous to the clock.
module tep_evt_qual
    import tep_pkg::*;
(
    input  logic       ovf,
    input  logic       mat,
    input  trig_mode_e mode,
    input  logic       run,
    output logic       armed,
    output logic       hit
);
    logic mode_on;
    logic mat_ok;

    // Decode which trigger modes arm the driver; reserved counts as off.
    always_comb begin
        mode_on = (mode == TRIG_OVF) || (mode == TRIG_BOTH);
        mat_ok  = (mode == TRIG_BOTH);
    end

    // Combine running state with the qualified events.
    always_comb begin
        armed = run && mode_on;
        hit   = armed && (ovf || (mat_ok && mat));
    end
endmodule

// File: rtl/tep_lvl_next.sv
// Next-level computation: picks the pin level for the next cycle from the
// current level, the qualified event and the control bits.
// Assumes a single combined hit per cycle (coincident events already merged).
module tep_lvl_next (
    input  logic cur,
    input  logic armed,
    input  logic hit,
    input  logic toggle_sel,
    input  logic idle_lvl,
    input  logic pin_is_in,
    output logic nxt
);
    // Priority: input direction holds, idle forces, then toggle or pulse.
    always_comb begin
        if (pin_is_in)
            nxt = cur;
        else if (!armed)
            nxt = idle_lvl;
        else if (toggle_sel)
            nxt = hit ? ~cur : cur;
        else
            nxt = hit ? ~idle_lvl : idle_lvl;
    end
endmodule

// File: rtl/tep_pin_drv.sv
// Timer event pin driver top: registers the pin level computed from the
// overflow/match events and control fields.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module tep_pin_drv
    import tep_pkg::*;
#(
    parameter bit RST_LVL = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ovf_evt,
    input  logic       mat_evt,
    input  logic [1:0] trig_mode,
    input  logic       toggle_sel,
    input  logic       idle_lvl,
    input  logic       pin_is_in,
    input  logic       run,
    output logic       pin_out
);
    trig_mode_e mode;
    logic       armed;
    logic       hit;
    logic       nxt;
    logic       pin_q;

    // Map the raw control field onto the mode type.
    always_comb mode = trig_mode_e'(trig_mode);

    tep_evt_qual u_qual (
        .ovf   (ovf_evt),
        .mat   (mat_evt),
        .mode  (mode),
        .run   (run),
        .armed (armed),
        .hit   (hit)
    );

    tep_lvl_next u_next (
        .cur        (pin_q),
        .armed      (armed),
        .hit        (hit),
        .toggle_sel (toggle_sel),
        .idle_lvl   (idle_lvl),
        .pin_is_in  (pin_is_in),
        .nxt        (nxt)
    );

    // Pin level register, glitch-free output.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pin_q <= RST_LVL;
        else
            pin_q <= nxt;
    end

    assign pin_out = pin_q;
endmodule

// File: rtl/tep_pin_drv_chk.sv
// Checker for tep_pin_drv: port-level temporal properties, bound to the top.
module tep_pin_drv_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ovf_evt,
    input logic       mat_evt,
    input logic [1:0] trig_mode,
    input logic       toggle_sel,
    input logic       idle_lvl,
    input logic       pin_is_in,
    input logic       run,
    input logic       pin_out
);
    logic on_mode;
    logic drive;
    logic qual;

    // Independent view of the armed/qualified condition from ports.
    always_comb begin
        on_mode = (trig_mode == 2'd1) || (trig_mode == 2'd2);
        drive   = !pin_is_in && run && on_mode;
        qual    = ovf_evt || (trig_mode == 2'd2 && mat_evt);
    end

    // R1
    rst_lvl_chk: assert property (@(posedge clk) !rst_n |=> pin_out == 1'b0);

    // R3
    idle_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_is_in && !(run && on_mode)) |=> pin_out == $past(idle_lvl));

    // R4
    toggle_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive && toggle_sel && qual) |=> pin_out != $past(pin_out));

    // R5
    ovf_only_mat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive && toggle_sel && trig_mode == 2'd1 && mat_evt && !ovf_evt) |=> $stable(pin_out));

    // R8
    pulse_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive && !toggle_sel) |=> pin_out == ($past(qual) ? !$past(idle_lvl) : $past(idle_lvl)));

    // R9
    toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive && toggle_sel && !qual) |=> $stable(pin_out));

    // R10
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_is_in |=> $stable(pin_out));
endmodule

bind tep_pin_drv tep_pin_drv_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ovf_evt    (ovf_evt),
    .mat_evt    (mat_evt),
    .trig_mode  (trig_mode),
    .toggle_sel (toggle_sel),
    .idle_lvl   (idle_lvl),
    .pin_is_in  (pin_is_in),
    .run        (run),
    .pin_out    (pin_out)
);

// File: tb/tb_tep_pin_drv.sv
// Scoreboard bench for tep_pin_drv: the driver task applies stimulus at the
// falling edge and queues the expected pin level; the monitor compares after
// the following rising edge.
module tb_tep_pin_drv;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ovf_evt = 1'b0;
    logic       mat_evt = 1'b0;
    logic [1:0] trig_mode = 2'd0;
    logic       toggle_sel = 1'b0;
    logic       idle_lvl = 1'b0;
    logic       pin_is_in = 1'b0;
    logic       run = 1'b0;
    logic       pin_out;

    typedef struct {
        logic  exp;
        string req;
    } item_t;

    item_t q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    logic  model = 1'b0;
    bit    done = 1'b0;

    always #10 clk = ~clk;

    tep_pin_drv dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ovf_evt    (ovf_evt),
        .mat_evt    (mat_evt),
        .trig_mode  (trig_mode),
        .toggle_sel (toggle_sel),
        .idle_lvl   (idle_lvl),
        .pin_is_in  (pin_is_in),
        .run        (run),
        .pin_out    (pin_out)
    );

    // Monitor: compare after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_cmp++;
                if (pin_out !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: pin_out=%0b expected=%0b", it.req, pin_out, it.exp);
                end
            end
        end
    end

    task automatic rst_cycle();
        @(negedge clk);
        rst_n = 1'b0;
        model = 1'b0;
        q.push_back('{exp: 1'b0, req: "R1"});
    endtask

    // Driver: apply one cycle of stimulus and queue the model's next level.
    task automatic step(input logic o, input logic m, input logic [1:0] md,
                        input logic tg, input logic il, input logic di,
                        input logic rn, input string req);
        logic hit;
        @(negedge clk);
        rst_n = 1'b1;
        ovf_evt = o; mat_evt = m; trig_mode = md; toggle_sel = tg;
        idle_lvl = il; pin_is_in = di; run = rn;
        hit = o || (md == 2'd2 && m);
        if (di) begin
            model = model;
        end else if (!rn || md == 2'd0 || md == 2'd3) begin
            model = il;
        end else if (tg) begin
            if (hit) model = ~model;
        end else begin
            model = hit ? ~il : il;
        end
        q.push_back('{exp: model, req: req});
    endtask

    // Watchdog.
    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_cycle(); rst_cycle();                            // R1
        //    o  m  md  tg il di rn
        step(0, 0, 2'd0, 1, 1, 0, 1, "R3");   // none mode -> idle 1
        step(0, 0, 2'd0, 1, 0, 0, 1, "R3");   // idle 0
        step(1, 0, 2'd1, 1, 0, 0, 1, "R4");   // toggle 0->1
        step(0, 0, 2'd1, 1, 0, 0, 1, "R9");   // hold 1
        step(1, 0, 2'd1, 1, 0, 0, 1, "R4");   // toggle 1->0
        step(0, 1, 2'd1, 1, 0, 0, 1, "R5");   // match ignored
        step(0, 1, 2'd1, 1, 0, 0, 1, "R5");
        step(0, 1, 2'd2, 1, 0, 0, 1, "R6");   // match toggles 0->1
        step(1, 1, 2'd2, 1, 0, 0, 1, "R7");   // once: 1->0
        step(1, 1, 2'd2, 1, 0, 0, 1, "R7");   // once: 0->1
        step(1, 0, 2'd1, 1, 0, 0, 0, "R3");   // stopped -> idle 0
        step(1, 1, 2'd3, 1, 1, 0, 1, "R2");   // reserved -> idle 1
        step(1, 1, 2'd3, 1, 0, 0, 1, "R2");   // reserved -> idle 0
        step(1, 0, 2'd1, 0, 0, 0, 1, "R8");   // pulse high
        step(0, 0, 2'd1, 0, 0, 0, 1, "R8");   // back to 0
        step(0, 0, 2'd1, 0, 1, 0, 1, "R8");   // idle 1
        step(1, 0, 2'd1, 0, 1, 0, 1, "R8");   // pulse low
        step(0, 0, 2'd1, 0, 1, 0, 1, "R8");   // back to 1
        step(0, 1, 2'd1, 0, 1, 0, 1, "R5");   // match ignored in pulse
        step(0, 1, 2'd2, 0, 1, 0, 1, "R6");   // match pulses low
        step(0, 0, 2'd2, 0, 1, 0, 1, "R8");
        step(0, 0, 2'd0, 1, 1, 0, 1, "R3");   // pin at 1
        step(0, 0, 2'd0, 1, 0, 1, 1, "R10");  // input: no idle force
        step(1, 1, 2'd2, 1, 0, 1, 1, "R10");  // input: no toggle
        step(1, 0, 2'd1, 0, 0, 1, 1, "R10");  // input: no pulse
        step(0, 0, 2'd1, 1, 0, 1, 0, "R10");
        step(1, 0, 2'd1, 1, 0, 0, 1, "R4");   // output again: 1->0
        rst_cycle();                                        // R1
        step(0, 0, 2'd1, 1, 1, 0, 1, "R9");   // toggle, no event: hold 0
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule